// File: doc/BRIEF.md
# Flash Converter Sample Packer

This block sits behind the comparator bank of a 4-bit flash analog-to-digital converter. It takes one thermometer word from the comparators on every line-rate clock and passes it through two register stages so that metastable comparator outputs can settle. It then encodes the word straight into Gray code and packs eight successive samples into one wide word. A one-cycle strobe marks each new word, and the strobes arrive at one eighth of the line rate.

A runtime input selects the resolution. Full resolution gives 4-bit samples. The reduced mode gives 3-bit samples and reads only the odd-numbered comparators, so the even ones can be powered down. Each sample carries the mode value that was present when the sample was taken. A whole output word uses the mode of its first sample, so no word ever mixes the two resolutions. The downstream equaliser samples the packed word whenever the strobe is high.

Top module: `flash_adc_backend`

## Requirements
- R1: A group's word and its strobe appear on the second rising edge after the edge that captured the group's last comparator word. This fixed latency of 2 edges is the localparam `LATENCY`.
- R2: In full-resolution mode, a clean thermometer input with its n lowest bits set (n = 0..15) produces the 4-bit sample n XOR (n >> 1).
- R3: If any single comparator bit of a clean thermometer input is inverted, the sample differs from the correct code in at most one bit position.
- R4: In reduced mode (`lowres` = 1), only comparators 1, 3, 5, 7, 9, 11 and 13 are used. With m of them set, bits 3..1 of the sample hold m XOR (m >> 1) and bit 0 is 0.
- R5: Bits 4k+3..4k of the output word hold the k-th sample of the group, and sample 0 is the earliest in time.
- R6: `word_vld` is high for exactly one clock per completed group of eight samples. Under a continuous input stream it is high every eighth cycle, and `word` does not change while `word_vld` is low.
- R7: A synchronous reset clears both synchroniser stages, the lane counter, `word` (which reads 0) and `word_vld`. No strobe appears until eight samples captured after the reset have completed a group, and a group that reset interrupts produces no strobe.
- R8: The `lowres` value is captured together with each comparator word. Every sample of a group is encoded in the mode captured with the group's first sample, so a mode change in the middle of a group takes effect at the next group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| lowres | input | 1 | 1 selects 3-bit reduced mode, 0 selects 4-bit mode |
| cmp | input | 15 | Comparator thermometer word; bit i is high when the input is above level i+1 |
| word | output | 32 | Eight packed Gray samples, earliest sample in the low nibble |
| word_vld | output | 1 | One-cycle strobe marking a new `word` |

## Verification
Two events can land on the same clock edge. The first pair is the completion of a group, which writes the eighth lane and raises the strobe, and the synchronous reset. The bench raises reset on exactly the edge that would store the eighth sample of a group. It then checks that no strobe appears and that the next word is built only from samples taken after reset. The second pair is a mode change and the last sample of a group. Here `lowres` flips on the last sample of one group and again in the middle of the next group. The scoreboard expects the old mode for the finished word and the first sample's mode for every lane of the following word.

// File: rtl/flash_adc_backend.sv
module flash_adc_backend #(
  parameter int SPW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lowres,
  input  logic [14:0]       cmp,
  output logic [4*SPW-1:0]  word,
  output logic              word_vld
);
  localparam int CW = $clog2(SPW);
  localparam int WW = 4 * SPW;
  localparam int LATENCY = 2;

  logic [14:0]   t1, t2;
  logic          m1, m2, v1, v2, grp_lr, lr;
  logic [CW-1:0] lane;
  logic [WW-1:0] pack;
  logic [3:0]    g4, code;

  always_ff @(posedge clk) begin
    if (rst) begin
      t1 <= '0; t2 <= '0;
      m1 <= 1'b0; m2 <= 1'b0;
      v1 <= 1'b0; v2 <= 1'b0;
    end else begin
      t1 <= cmp;  t2 <= t1;
      m1 <= lowres; m2 <= m1;
      v1 <= 1'b1; v2 <= v1;
    end
  end

  assign g4[3] = t2[7];
  assign g4[2] = t2[3] & ~t2[11];
  assign g4[1] = (t2[1] & ~t2[5]) | (t2[9] & ~t2[13]);
  assign g4[0] = (t2[0] & ~t2[2]) | (t2[4] & ~t2[6]) | (t2[8] & ~t2[10]) | (t2[12] & ~t2[14]);

  assign lr   = (lane == '0) ? m2 : grp_lr;
  assign code = lr ? {g4[3:1], 1'b0} : g4;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane     <= '0;
      pack     <= '0;
      word     <= '0;
      word_vld <= 1'b0;
      grp_lr   <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (v2) begin
        pack[{lane, 2'b00} +: 4] <= code;
        if (lane == '0) grp_lr <= m2;
        if (lane == CW'(SPW - 1)) begin
          lane     <= '0;
          word     <= {code, pack[WW-5:0]};
          word_vld <= 1'b1;
        end else begin
          lane <= lane + CW'(1);
        end
      end
    end
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst || !armed)
    word_vld |=> !word_vld);
  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !word_vld |-> $stable(word));
  a_r5_lane_wrap: assert property (@(posedge clk) disable iff (rst || !armed)
    word_vld |-> lane == '0);
  a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> !word_vld);
  a_r8_mode_held: assert property (@(posedge clk) disable iff (rst || !armed)
    (v2 && lane != '0) |=> $stable(grp_lr));
  a_r1_strobe_needs_data: assert property (@(posedge clk) disable iff (rst || !armed)
    word_vld |-> $past(v2, LATENCY - 1));
endmodule

// File: tb/tb_flash_adc_backend.sv
module tb_flash_adc_backend;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lowres = 1'b0;
  logic [14:0] cmp = '0;
  logic [31:0] word;
  logic        word_vld;

  flash_adc_backend dut (.clk(clk), .rst(rst), .lowres(lowres), .cmp(cmp),
                         .word(word), .word_vld(word_vld));

  always #2.5 clk = ~clk;

  typedef struct { logic [3:0] exp; bit tol; int cap; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, ecount = 0, slot = 0;
  bit gmode = 1'b0, prev_vld = 1'b0, done = 1'b0;
  logic [31:0] last_word = '0;

  function automatic logic [14:0] therm(int n);
    return 15'((32'd1 << n) - 1);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic send(int n, bit mode, int flip, string req);
    item_t it;
    int m;
    cmp = therm(n);
    if (flip >= 0) cmp[flip] = ~cmp[flip];
    lowres = mode;
    if (slot == 0) gmode = mode;
    if (gmode) begin
      m = n / 2;
      it.exp = {3'(m ^ (m >> 1)), 1'b0};
    end else begin
      it.exp = 4'(n ^ (n >> 1));
    end
    it.tol = (flip >= 0);
    it.cap = ecount + 1;
    it.req = req;
    q.push_back(it);
    slot = (slot + 1) % 8;
    @(negedge clk);
  endtask

  task automatic do_reset(int cycles);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    check(word == 32'h0 && !word_vld, "R7", "state under reset", {word_vld, word[30:0]}, 32'h0);
    q.delete();
    slot = 0;
    last_word = '0;
    prev_vld = 1'b0;
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    ecount = ecount + 1;
    #1;
    if (!rst && !done) begin
      if (word_vld) begin
        check(!prev_vld, "R6", "strobe longer than one cycle", 32'd1, 32'd0);
        if (q.size() < 8) begin
          check(1'b0, "R7", "strobe with fewer than eight samples", q.size(), 32'd8);
        end else begin
          check(ecount - q[7].cap == LAT, "R1", "latency", ecount - q[7].cap, LAT);
          for (int k = 0; k < 8; k++) begin
            item_t it;
            logic [3:0] got;
            it = q.pop_front();
            got = word[4*k +: 4];
            if (it.tol)
              check($countones(got ^ it.exp) <= 1, "R3", $sformatf("lane %0d", k), got, it.exp);
            else
              check(got == it.exp, it.req, $sformatf("lane %0d (R5)", k), got, it.exp);
          end
        end
        last_word = word;
      end else begin
        check(word == last_word, "R6", "word changed without strobe", word, last_word);
        if (q.size() >= 8 && q[7].cap + LAT < ecount) begin
          check(1'b0, "R6", "missing strobe", 32'd0, 32'd1);
          repeat (8) void'(q.pop_front());
        end
      end
      prev_vld = word_vld;
    end
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(4);
    for (int i = 0; i < 16; i++) send(i, 1'b0, -1, "R2");
    for (int i = 0; i < 16; i++) send(15 - i, 1'b0, -1, "R2");
    for (int i = 0; i < 16; i++) send(i, 1'b1, -1, "R4");
    for (int i = 0; i < 8; i++) send((i * 5) % 16, i >= 3, -1, "R8");
    for (int i = 0; i < 7; i++) send((i * 3) % 16, 1'b1, -1, "R8");
    send(9, 1'b0, -1, "R8");
    for (int i = 0; i < 8; i++) send(i + 4, (i % 3) == 0 ? 1'b0 : 1'b1, -1, "R8");
    for (int i = 0; i < 16; i++) send((i * 7) % 16, 1'b0, i % 15, "R3");
    for (int i = 0; i < 8; i++) send((i * 11) % 16, 1'b1, (i * 4) % 15, "R3");
    for (int i = 0; i < 8; i++) send(i, 1'b0, -1, "R7");
    do_reset(2);
    for (int i = 0; i < 7; i++) send(15 - i, 1'b0, -1, "R7");
    repeat (3) send(1, 1'b0, -1, "R7");
    do_reset(3);
    for (int i = 0; i < 24; i++) send((i * 9) % 16, i >= 8 && i < 16, -1, "R5");
    for (int i = 0; i < 4; i++) send(0, 1'b0, -1, "R6");
    done = 1'b1;
    check(q.size() == 4, "R6", "groups left unpacked", q.size(), 32'd4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule